// File: doc/BRIEF.md
# Coincident Row/Column Word Selector

This block turns a flat word address into a single active word-select line. It does not use one wide decoder with a gate for every word. The address is split into two halves. The upper half drives a small row decoder and the lower half drives a small column decoder. Each decoder raises exactly one of its lines. A word line is active only where the active row and the active column cross, so the word array is laid out as a square matrix. This takes far fewer and narrower decoding gates than a flat decoder of the same reach.

A single enable gates both decoders. With the enable low, no row, no column and no word is driven, so an array behind the block keeps all of its contents. The block holds no state. It has no clock and no reset, and every output follows the inputs in the same evaluation. The row and column lines are brought out as well as the word lines, so a physical array can use the two small buses directly.

Top module: `coincident_word_select`

## Requirements
- R1: With `en` high, `row_sel` has exactly one bit set, at index `addr[9:5]` (the five most significant address bits).
- R2: With `en` high, `col_sel` has exactly one bit set, at index `addr[4:0]` (the five least significant address bits).
- R3: With `en` high, `word_sel` has exactly one bit set, at flat index `addr[9:5]*32 + addr[4:0]`, which equals `addr` read as an unsigned binary number.
- R4: Every word line is the AND of its row and column lines: `word_sel[r*32+c]` is 1 exactly when `row_sel[r]` and `col_sel[c]` are both 1.
- R5: With `en` low, all bits of `row_sel`, `col_sel` and `word_sel` are 0, whatever the value of `addr`.
- R6: The block is combinational. A new address moves the selection at once, and the previously selected row, column and word lines drop to 0 with no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Global enable for both decoders |
| addr | input | 10 | Word address; upper 5 bits select the row, lower 5 bits select the column |
| row_sel | output | 32 | One-hot row lines (all zero when disabled) |
| col_sel | output | 32 | One-hot column lines (all zero when disabled) |
| word_sel | output | 1024 | Flattened word-select matrix, bit r*32+c for row r and column c |

## Verification
All results are due in the same evaluation as the stimulus, because no register lies between the inputs and the outputs. The bench changes `en` and `addr` on a falling clock edge. It samples half a period later, so the combinational paths have settled before any comparison. The bench visits every one of the 1,024 addresses with the enable high, and sweeps addresses with the enable low. It also steps between addresses to confirm that the old selection is released in the same sample.

// File: rtl/coin_sel_pkg.sv
package coin_sel_pkg;
    // Address split between the row and column decoders
    localparam int unsigned ROW_ADDR_BITS = 5;
    localparam int unsigned COL_ADDR_BITS = 5;
    localparam int unsigned ADDR_BITS     = ROW_ADDR_BITS + COL_ADDR_BITS;
    localparam int unsigned ROW_LINES     = 1 << ROW_ADDR_BITS;
    localparam int unsigned COL_LINES     = 1 << COL_ADDR_BITS;
    localparam int unsigned WORD_LINES    = ROW_LINES * COL_LINES;

    // Split address view
    typedef struct packed {
        logic [ROW_ADDR_BITS-1:0] row;
        logic [COL_ADDR_BITS-1:0] col;
    } split_addr_t;
endpackage

// File: rtl/onehot_line_decoder.sv
module onehot_line_decoder #(
    parameter int unsigned SEL_BITS = 5,
    localparam int unsigned LINES   = 1 << SEL_BITS
) (
    input  logic                en_i,
    input  logic [SEL_BITS-1:0] sel_i,
    output logic [LINES-1:0]    line_o
);
    // One comparator per output line
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_o[i] = en_i && (sel_i == SEL_BITS'(i));
    end

    always_comb begin
        if (en_i) begin
            p_single_line_r1: assert ($countones(line_o) == 1)
                else $error("decoder: enabled output not one-hot");
            p_line_at_sel_r2: assert (line_o[sel_i])
                else $error("decoder: selected line not raised");
        end else begin
            p_idle_lines_r5: assert (line_o == '0)
                else $error("decoder: line active while disabled");
        end
    end
endmodule

// File: rtl/coincidence_matrix.sv
module coincidence_matrix #(
    parameter int unsigned ROWS  = 32,
    parameter int unsigned COLS  = 32,
    localparam int unsigned CELLS = ROWS * COLS
) (
    input  logic [ROWS-1:0]  row_i,
    input  logic [COLS-1:0]  col_i,
    output logic [CELLS-1:0] cell_o
);
    // One AND gate at every row/column crossing
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign cell_o[r*COLS + c] = row_i[r] & col_i[c];
        end
    end

    always_comb begin
        if ($onehot(row_i) && $onehot(col_i)) begin
            p_one_cell_r4: assert ($countones(cell_o) == 1)
                else $error("matrix: crossing of single lines not unique");
        end
        if (row_i == '0 || col_i == '0) begin
            p_no_cell_r5: assert (cell_o == '0)
                else $error("matrix: cell active without both lines");
        end
    end
endmodule

// File: rtl/coincident_word_select.sv
module coincident_word_select
    import coin_sel_pkg::*;
(
    input  logic                  en,
    input  logic [ADDR_BITS-1:0]  addr,
    output logic [ROW_LINES-1:0]  row_sel,
    output logic [COL_LINES-1:0]  col_sel,
    output logic [WORD_LINES-1:0] word_sel
);
    split_addr_t addr_s;
    assign addr_s = split_addr_t'(addr);

    onehot_line_decoder #(.SEL_BITS(ROW_ADDR_BITS)) u_row_dec (
        .en_i  (en),
        .sel_i (addr_s.row),
        .line_o(row_sel)
    );

    onehot_line_decoder #(.SEL_BITS(COL_ADDR_BITS)) u_col_dec (
        .en_i  (en),
        .sel_i (addr_s.col),
        .line_o(col_sel)
    );

    coincidence_matrix #(.ROWS(ROW_LINES), .COLS(COL_LINES)) u_matrix (
        .row_i (row_sel),
        .col_i (col_sel),
        .cell_o(word_sel)
    );

    always_comb begin
        if (en) begin
            p_word_at_addr_r3: assert (word_sel[addr] && $countones(word_sel) == 1)
                else $error("top: word line does not match address");
        end else begin
            p_word_idle_r5: assert (word_sel == '0)
                else $error("top: word line active while disabled");
        end
    end
endmodule

// File: tb/coincident_word_select_tb.sv
module coincident_word_select_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int NR = 32;
    localparam int NC = 32;
    localparam int NW = 1024;

    logic          clk = 1'b0;
    logic          en;
    logic [AW-1:0] addr;
    logic [NR-1:0] row_sel;
    logic [NC-1:0] col_sel;
    logic [NW-1:0] word_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coincident_word_select u_dut (
        .en      (en),
        .addr    (addr),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .word_sel(word_sel)
    );

    // Drive on falling edge, sample half a period later
    task automatic apply(input logic e, input logic [AW-1:0] a);
        @(negedge clk);
        en   = e;
        addr = a;
        #(CLK_PERIOD/2 - 1);
    endtask

    task automatic check_all(input string req, input logic e, input logic [AW-1:0] a);
        logic [NR-1:0] exp_r;
        logic [NC-1:0] exp_c;
        logic [NW-1:0] exp_w;
        exp_r = '0; exp_c = '0; exp_w = '0;
        if (e) begin
            exp_r[a[9:5]] = 1'b1;
            exp_c[a[4:0]] = 1'b1;
            exp_w[a]      = 1'b1;
        end
        n_checks++;
        if (row_sel !== exp_r || col_sel !== exp_c || word_sel !== exp_w) begin
            n_fails++;
            $display("FAIL %s addr=%0d en=%0b: row=%h/%h col=%h/%h word_ones=%0d word_at_addr=%0b (expected row/col as shown, word one-hot at %0d)",
                     req, a, e, row_sel, exp_r, col_sel, exp_c,
                     $countones(word_sel), word_sel[a], e ? int'(a) : -1);
        end
    endtask

    // R5: idle with enable low
    task automatic t_idle;
        apply(1'b0, '0);
        check_all("R5 idle", 1'b0, '0);
    endtask

    // R1 R2 R3 R4: every address with enable high
    task automatic t_full_sweep;
        for (int i = 0; i < NW; i++) begin
            apply(1'b1, AW'(i));
            check_all("R1/R2/R3/R4 sweep", 1'b1, AW'(i));
        end
    endtask

    // R5: enable low ignores address
    task automatic t_disabled_sweep;
        for (int i = 0; i < NW; i += 37) begin
            apply(1'b0, AW'(i));
            check_all("R5 disabled", 1'b0, AW'(i));
        end
        apply(1'b0, 10'd1023);
        check_all("R5 disabled max", 1'b0, 10'd1023);
    endtask

    // R3 R4: corner addresses at row/column edges
    task automatic t_corners;
        logic [AW-1:0] pts [6] = '{10'd0, 10'd31, 10'd32, 10'd992, 10'd1023, 10'd527};
        foreach (pts[k]) begin
            apply(1'b1, pts[k]);
            check_all("R3 R4 corner", 1'b1, pts[k]);
        end
    endtask

    // R6: selection moves and releases at once, enable toggles
    task automatic t_step_release;
        apply(1'b1, 10'd5);
        check_all("R6 step a", 1'b1, 10'd5);
        apply(1'b1, 10'd998);
        check_all("R6 step b", 1'b1, 10'd998);
        apply(1'b0, 10'd998);
        check_all("R6 drop enable", 1'b0, 10'd998);
        apply(1'b1, 10'd998);
        check_all("R6 re-enable", 1'b1, 10'd998);
        apply(1'b1, 10'd5);
        check_all("R6 step back", 1'b1, 10'd5);
    endtask

    initial begin
        en = 1'b0;
        addr = '0;
        t_idle();
        t_full_sweep();
        t_disabled_sweep();
        t_corners();
        t_step_release();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule